// File: doc/BRIEF.md
# Thread Block Admission Controller

This block decides, one request at a time, whether a new thread block can be placed on a single multithreaded compute core. Each request carries the number of threads in the block and the number of registers each thread needs. The controller keeps a record of the blocks already resident: how many slots are in use, how many threads they hold in total, and how much of the register budget they own. It accepts a request only when the block fits under all three limits at once.

When a block is admitted, the controller gives it the lowest-numbered free slot. One cycle later it reports that slot and the number of 32-thread warps the block produces. A completion input names a slot whose block has finished. That slot's threads and registers go back to the pool. Requests are served strictly in arrival order: a request that does not fit yet holds the interface until enough resources come back. A request that could never fit is consumed and flagged with a reject pulse.

Top module: `blk_admit_ctrl`

## Requirements
- R1: After reset, no slot is resident and the admit pulse, reject pulse and error flag are all 0.
- R2: At most 8 blocks are resident at once. A request that would otherwise fit stalls (ready low) while all 8 slots are occupied.
- R3: The total thread count of the resident blocks never exceeds 768. A request that would push it past 768 stalls.
- R4: Each block owns threads × registers-per-thread registers. The resident total never exceeds 8192. A request that would push it past 8192 stalls.
- R5: A handshake (valid and ready high at a clock edge) that admits a block raises the admit pulse for exactly the next cycle. In that cycle the warp count equals ceil(threads/32).
- R6: An admitted block gets the lowest-numbered slot that was free in the handshake cycle, reported alongside the admit pulse.
- R7: While the head request does not fit, ready stays low and no admit or reject pulse follows. The request is never bypassed.
- R8: A completion naming a resident slot frees that slot, its threads and its registers from the next cycle on. A stalled request is admitted as soon as the freed resources make it fit.
- R9: A request with 0 threads, more than 512 threads, or more than 8192 registers in total is taken immediately (ready high). It raises the reject pulse for one cycle and consumes no resources.
- R10: A completion naming a slot that is not resident changes no accounting. It sets the error flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request fits or must be rejected; a handshake takes place at this edge |
| req_threads | input | 10 | Threads in the requested block |
| req_regs | input | 8 | Registers per thread |
| adm_valid | output | 1 | One-cycle pulse: a block was admitted |
| adm_slot | output | 3 | Slot assigned to the admitted block |
| adm_warps | output | 5 | Warps created for the admitted block |
| rej_pulse | output | 1 | One-cycle pulse: request can never fit and was dropped |
| done_valid | input | 1 | A slot's block has completed |
| done_slot | input | 3 | Slot being released |
| err_flag | output | 1 | Sticky: completion of a non-resident slot |

## Verification
The hardest states to reach are the ones where only one of the three limits is binding. Examples are eight small blocks blocking on slots, two large blocks blocking on threads, and a register-heavy block blocking on the budget. Each of these must be held until a particular completion turns it into an admission. The bench drives a long pseudo-random mix of thread and register counts drawn around the warp and limit boundaries, tracks an arithmetic model of the resident set, and releases the lowest resident slot whenever the model predicts a stall. Each stall is classified by the limit that caused it and then resolved through completions. It also releases random slots in between to scatter the free-slot pattern.

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl #(
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_THREADS = 768,
  parameter int REG_BUDGET  = 8192,
  parameter int BLK_MAX     = 512,
  parameter int WARP_SIZE   = 32,
  parameter int TW          = 10,
  parameter int RW          = 8,
  localparam int SW  = $clog2(MAX_BLOCKS),
  localparam int TTW = $clog2(MAX_THREADS + 1),
  localparam int RBW = $clog2(REG_BUDGET + 1),
  localparam int NW  = TW + RW,
  localparam int WW  = $clog2(BLK_MAX / WARP_SIZE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [TW-1:0] req_threads,
  input  logic [RW-1:0] req_regs,
  output logic          adm_valid,
  output logic [SW-1:0] adm_slot,
  output logic [WW-1:0] adm_warps,
  output logic          rej_pulse,
  input  logic          done_valid,
  input  logic [SW-1:0] done_slot,
  output logic          err_flag
);

  logic [MAX_BLOCKS-1:0] live;
  logic [TW-1:0]         thr_q [MAX_BLOCKS];
  logic [RBW-1:0]        reg_q [MAX_BLOCKS];
  logic [TTW-1:0]        thr_used;
  logic [RBW-1:0]        reg_used;

  logic [NW-1:0]  need;
  logic [TTW:0]   thr_sum;
  logic [NW:0]    reg_sum;
  logic           never, fits, any_free, take, drop, done_ok, done_bad;
  logic [SW-1:0]  pick;
  logic [TW:0]    wsum;

  assign need     = NW'(req_threads) * NW'(req_regs);
  assign thr_sum  = (TTW+1)'(thr_used) + (TTW+1)'(req_threads);
  assign reg_sum  = (NW+1)'(reg_used) + (NW+1)'(need);
  assign never    = (req_threads == '0) || (req_threads > TW'(BLK_MAX)) ||
                    (need > NW'(REG_BUDGET));
  assign fits     = !never && any_free && (thr_sum <= (TTW+1)'(MAX_THREADS)) &&
                    (reg_sum <= (NW+1)'(REG_BUDGET));
  assign req_ready = fits || never;
  assign take     = req_valid && fits;
  assign drop     = req_valid && never;
  assign done_ok  = done_valid && live[done_slot];
  assign done_bad = done_valid && !live[done_slot];
  assign wsum     = (TW+1)'(req_threads) + (TW+1)'(WARP_SIZE - 1);

  always_comb begin
    any_free = 1'b0;
    pick     = '0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--)
      if (!live[i]) begin
        any_free = 1'b1;
        pick     = SW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      for (int i = 0; i < MAX_BLOCKS; i++) begin
        thr_q[i] <= '0;
        reg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < MAX_BLOCKS; i++) begin
        if (take && pick == SW'(i)) begin
          live[i]  <= 1'b1;
          thr_q[i] <= req_threads;
          reg_q[i] <= RBW'(need);
        end else if (done_ok && done_slot == SW'(i)) begin
          live[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_used  <= '0;
      reg_used  <= '0;
      adm_valid <= 1'b0;
      adm_slot  <= '0;
      adm_warps <= '0;
      rej_pulse <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      thr_used  <= thr_used + (take ? TTW'(req_threads) : '0)
                            - (done_ok ? TTW'(thr_q[done_slot]) : '0);
      reg_used  <= reg_used + (take ? RBW'(need) : '0)
                            - (done_ok ? reg_q[done_slot] : '0);
      adm_valid <= take;
      adm_slot  <= pick;
      adm_warps <= WW'(wsum / (TW+1)'(WARP_SIZE));
      rej_pulse <= drop;
      err_flag  <= err_flag | done_bad;
    end
  end

  p_thread_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_used <= TTW'(MAX_THREADS));
  p_reg_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_used <= RBW'(REG_BUDGET));
  p_warps_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adm_valid |-> adm_warps != '0);
  p_slot_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adm_valid |-> live[adm_slot]);
  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !adm_valid && !rej_pulse);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !live[$past(done_slot)]);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

endmodule

// File: tb/blk_admit_ctrl_test.sv
`timescale 1ns/1ps
module blk_admit_ctrl_test;
  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, req_ready;
  logic [9:0] req_threads = 0;
  logic [7:0] req_regs = 0;
  logic       adm_valid, rej_pulse, err_flag;
  logic [2:0] adm_slot;
  logic [4:0] adm_warps;
  logic       done_valid = 0;
  logic [2:0] done_slot = 0;

  int total = 0, bad = 0;
  int m_live [8];
  int m_thr [8];
  int m_reg [8];
  int unsigned seed = 32'h1234_5678;

  blk_admit_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_regs(req_regs), .adm_valid(adm_valid),
    .adm_slot(adm_slot), .adm_warps(adm_warps), .rej_pulse(rej_pulse),
    .done_valid(done_valid), .done_slot(done_slot), .err_flag(err_flag));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic do_reset();
    rst_n = 0; req_valid = 0; done_valid = 0;
    for (int i = 0; i < 8; i++) begin m_live[i] = 0; m_thr[i] = 0; m_reg[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
  endtask

  task automatic release_slot(input int k);
    done_slot = 3'(k); done_valid = 1;
    @(negedge clk);
    done_valid = 0;
    m_live[k] = 0; m_thr[k] = 0; m_reg[k] = 0;
    #1;
  endtask

  task automatic do_req(input int thr, input int rg);
    int nb, nt, nr, low, need;
    bit never, fits;
    req_threads = 10'(thr); req_regs = 8'(rg); req_valid = 1;
    #1;
    forever begin
      nb = 0; nt = 0; nr = 0; low = -1;
      for (int i = 0; i < 8; i++) begin
        nb += m_live[i]; nt += m_thr[i]; nr += m_reg[i];
        if (!m_live[i] && low < 0) low = i;
      end
      need  = thr * rg;
      never = (thr == 0) || (thr > 512) || (need > 8192);
      fits  = !never && (nb < 8) && (nt + thr <= 768) && (nr + need <= 8192);
      chk(req_ready == (never || fits), "R7 ready", int'(req_ready), int'(never || fits));
      if (never || fits) begin
        @(negedge clk);
        req_valid = 0;
        #1;
        if (fits) begin
          chk(adm_valid == 1, "R5 admit pulse", int'(adm_valid), 1);
          chk(adm_warps == 5'((thr + 31) / 32), "R5 warps", int'(adm_warps), (thr + 31) / 32);
          chk(adm_slot == 3'(low), "R6 R8 slot", int'(adm_slot), low);
          chk(rej_pulse == 0, "R9 no reject", int'(rej_pulse), 0);
          m_live[low] = 1; m_thr[low] = thr; m_reg[low] = need;
        end else begin
          chk(rej_pulse == 1, "R9 reject", int'(rej_pulse), 1);
          chk(adm_valid == 0, "R9 no admit", int'(adm_valid), 0);
        end
        break;
      end else begin
        low = -1;
        for (int i = 7; i >= 0; i--) if (m_live[i]) low = i;
        if (low < 0) begin chk(0, "R7 model", 0, 1); req_valid = 0; break; end
        release_slot(low);
        if (nb == 8)
          chk(adm_valid == 0 && rej_pulse == 0, "R2 stall", int'(adm_valid), 0);
        else if (nt + thr > 768)
          chk(adm_valid == 0 && rej_pulse == 0, "R3 stall", int'(adm_valid), 0);
        else
          chk(adm_valid == 0 && rej_pulse == 0, "R4 stall", int'(adm_valid), 0);
      end
    end
  endtask

  int tc [12] = '{1, 31, 32, 33, 64, 100, 128, 256, 512, 0, 600, 1023};

  initial begin
    do_reset();
    chk(adm_valid == 0, "R1 admit", int'(adm_valid), 0);
    chk(rej_pulse == 0, "R1 reject", int'(rej_pulse), 0);
    chk(err_flag == 0, "R1 error", int'(err_flag), 0);

    done_slot = 3; done_valid = 1;
    @(negedge clk); done_valid = 0; #1;
    chk(err_flag == 1, "R10 set", int'(err_flag), 1);
    do_req(256, 32);
    do_req(1, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(err_flag == 1, "R10 sticky", int'(err_flag), 1);

    do_reset();
    chk(err_flag == 0, "R1 error cleared", int'(err_flag), 0);
    for (int i = 0; i < 8; i++) do_req(32, 1);
    do_req(32, 1);
    do_reset();
    do_req(512, 1); do_req(256, 1); do_req(1, 1);
    do_reset();
    do_req(256, 32); do_req(1, 1);
    do_reset();
    do_req(0, 5); do_req(513, 1); do_req(512, 17);

    for (int n = 0; n < 500; n++) begin
      int thr, rg, k;
      thr = tc[rnd() % 12];
      rg  = (rnd() % 8 == 0) ? 200 : 1 + int'(rnd() % 40);
      do_req(thr, rg);
      if (rnd() % 3 == 0) begin
        k = int'(rnd() % 8);
        for (int j = 0; j < 8; j++)
          if (m_live[(k + j) % 8]) begin release_slot((k + j) % 8); break; end
        chk(err_flag == 0, "R8 R10 release", int'(err_flag), 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule